// File: doc/BRIEF.md
# Column-Parallel 8b/10b Serial Readout

This block gathers readout bytes from several pixel columns at the same time and sends them off chip as a single serial stream. The fast readout clock drives only the serializer. The column side is paced by a matrix enable pulse, which divides the fast clock by five times the number of columns read in parallel. On each matrix pulse the block strobes the ready line of every active column and captures the words that are valid. In the slots that follow, it encodes those words with 8b/10b in ascending column order and shifts each 10-bit symbol out two bits per fast cycle. One bit is meant for the rising edge and one for the falling edge, so a 320 MHz clock yields 640 Mbit/s.

When no captured byte is waiting, the stream carries the K28.5 comma so that a receiver can keep symbol lock. When a frame has carried data and then every active column reports that it is exhausted, the block sends a single K28.7 end marker. The number of parallel columns is a configuration input. The block reads it on every matrix pulse and clamps it to the range 1 to `MAX_COLS`.

Top module: `colpar_serializer`

## Requirements
- R1: While rst_ni is low, ser_o is 2'b00. The first symbol after reset is K28.5 in its negative-disparity form, sent from the first rising edge after release.
- R2: mclk_en_o is high for one fast cycle in every 5*N cycles. N is ncols_i clamped to 1..MAX_COLS: 0 counts as 1, and values above MAX_COLS count as MAX_COLS. The first pulse falls in the cycle just before the first edge after reset release.
- R3: Outside the matrix pulse col_ready_o is all zero. During the pulse, bit i is high exactly when i < N, and valid words from columns i >= N are ignored.
- R4: A capture fills the N symbol slots that start after the pulse. Captured words go out in ascending column index, and columns without a valid word are skipped.
- R5: Each byte is coded as standard 8b/10b data (D.x.y) with running disparity, starting negative. Symbol bit 0 is code bit a, bits 0..5 are abcdei and bits 6..9 are fghj. The alternate 3b/4b code for y=7 is used as the standard rule requires.
- R6: Each symbol is sent LSB first over five fast cycles. ser_o[0] carries the earlier (rising-edge) bit and ser_o[1] the later (falling-edge) bit.
- R7: A slot with no captured byte waiting sends K28.5 (001111 1010 at negative disparity, 110000 0101 at positive).
- R8: K28.7 (001111 1000 / 110000 0111) is sent once, in the first free slot, after a matrix pulse that accepts no word while every active column has col_empty_i high and some word has been accepted since the previous marker.
- R9: When all N columns deliver a word, the last byte leaves in the slot that coincides with the next matrix pulse, while the new capture happens in that same cycle. No byte is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast readout clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ncols_i | input | $clog2(MAX_COLS+1) | Number of columns read in parallel |
| col_valid_i | input | MAX_COLS | Column word valid |
| col_data_i | input | 8*MAX_COLS | Column bytes, column i in bits 8i+7:8i |
| col_empty_i | input | MAX_COLS | Column has no further data in this frame |
| col_ready_o | output | MAX_COLS | Capture strobe per column |
| mclk_en_o | output | 1 | Divided matrix clock enable |
| ser_o | output | 2 | DDR pair: bit 0 rising edge, bit 1 falling edge |

## Verification
Two things happen on the edge that ends every matrix period: a new set of column words is captured, and the last slot of the previous period is loaded. With N columns all valid, the final byte of one period and the capture for the next land in the same cycle. The bench provokes this with all-valid captures on back-to-back periods, for every N it tries. It decodes the serial stream symbol by symbol and compares each symbol against its own 8b/10b model and its own prediction of byte order. A byte that is dropped, repeated or taken from the wrong capture shows up as a symbol mismatch.

// File: rtl/colser_pkg.sv
`timescale 1ns/1ps
package colser_pkg;
  typedef enum logic [1:0] {SYM_IDLE, SYM_DATA, SYM_EOF} sym_kind_e;

  // 5b/6b codes, negative-disparity form, bit a in the MSB
  function automatic logic [5:0] code6(input logic [4:0] x);
    case (x)
      5'd0:  code6 = 6'b100111;  5'd1:  code6 = 6'b011101;
      5'd2:  code6 = 6'b101101;  5'd3:  code6 = 6'b110001;
      5'd4:  code6 = 6'b110101;  5'd5:  code6 = 6'b101001;
      5'd6:  code6 = 6'b011001;  5'd7:  code6 = 6'b111000;
      5'd8:  code6 = 6'b111001;  5'd9:  code6 = 6'b100101;
      5'd10: code6 = 6'b010101;  5'd11: code6 = 6'b110100;
      5'd12: code6 = 6'b001101;  5'd13: code6 = 6'b101100;
      5'd14: code6 = 6'b011100;  5'd15: code6 = 6'b010111;
      5'd16: code6 = 6'b011011;  5'd17: code6 = 6'b100011;
      5'd18: code6 = 6'b010011;  5'd19: code6 = 6'b110010;
      5'd20: code6 = 6'b001011;  5'd21: code6 = 6'b101010;
      5'd22: code6 = 6'b011010;  5'd23: code6 = 6'b111010;
      5'd24: code6 = 6'b110011;  5'd25: code6 = 6'b100110;
      5'd26: code6 = 6'b010110;  5'd27: code6 = 6'b110110;
      5'd28: code6 = 6'b001110;  5'd29: code6 = 6'b101110;
      5'd30: code6 = 6'b011110;  default: code6 = 6'b101011;
    endcase
  endfunction

  // 3b/4b codes, negative-disparity form, bit f in the MSB
  function automatic logic [3:0] code4(input logic [2:0] y);
    case (y)
      3'd0: code4 = 4'b1011;  3'd1: code4 = 4'b1001;
      3'd2: code4 = 4'b0101;  3'd3: code4 = 4'b1100;
      3'd4: code4 = 4'b1101;  3'd5: code4 = 4'b1010;
      3'd6: code4 = 4'b0110;  default: code4 = 4'b1110;
    endcase
  endfunction

  // place bit a at index 0 so the symbol shifts out LSB first
  function automatic logic [9:0] lsb_first(input logic [5:0] s6, input logic [3:0] s4);
    for (int i = 0; i < 6; i++) lsb_first[i] = s6[5-i];
    for (int i = 0; i < 4; i++) lsb_first[6+i] = s4[3-i];
  endfunction
endpackage

// File: rtl/colser_rate.sv
`timescale 1ns/1ps
module colser_rate #(
  parameter int MAX_COLS = 4,
  parameter int NCOL_W   = $clog2(MAX_COLS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCOL_W-1:0] ncols_i,
  output logic [NCOL_W-1:0] n_eff_o,
  output logic              load_o,
  output logic              tick_o
);
  localparam logic [2:0] SLOT_LAST = 3'd4;

  logic [2:0]        slot_q;
  logic [NCOL_W-1:0] cnt_q, n_q;

  always_comb begin
    if (ncols_i == '0)                        n_eff_o = NCOL_W'(1);
    else if (ncols_i > NCOL_W'(MAX_COLS))     n_eff_o = NCOL_W'(MAX_COLS);
    else                                      n_eff_o = ncols_i;
  end

  assign load_o = (slot_q == SLOT_LAST);
  assign tick_o = load_o && (cnt_q == n_q - NCOL_W'(1));

  // reset lands on a slot boundary so the first edge loads and ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= SLOT_LAST;
      cnt_q  <= '0;
      n_q    <= NCOL_W'(1);
    end else begin
      slot_q <= load_o ? 3'd0 : slot_q + 3'd1;
      if (tick_o) begin
        cnt_q <= '0;
        n_q   <= n_eff_o;
      end else if (load_o) begin
        cnt_q <= cnt_q + NCOL_W'(1);
      end
    end
  end
endmodule

// File: rtl/colser_gather.sv
`timescale 1ns/1ps
module colser_gather
  import colser_pkg::*;
#(
  parameter int MAX_COLS = 4,
  parameter int NCOL_W   = $clog2(MAX_COLS + 1),
  parameter int IDX_W    = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      load_i,
  input  logic [NCOL_W-1:0]         n_eff_i,
  input  logic [MAX_COLS-1:0]       col_valid_i,
  input  logic [MAX_COLS-1:0][7:0]  col_data_i,
  input  logic [MAX_COLS-1:0]       col_empty_i,
  output logic [MAX_COLS-1:0]       col_ready_o,
  output sym_kind_e                 kind_o,
  output logic [7:0]                byte_o
);
  logic [MAX_COLS-1:0]      act, acc, pend_q;
  logic [MAX_COLS-1:0][7:0] data_q;
  logic [IDX_W-1:0]         sel_idx;
  logic                     sel_hit, all_empty, eof_q, frame_q;

  for (genvar i = 0; i < MAX_COLS; i++) begin : g_col
    assign act[i] = (NCOL_W'(i) < n_eff_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     data_q[i] <= '0;
      else if (acc[i]) data_q[i] <= col_data_i[i];
    end
  end

  assign col_ready_o = tick_i ? act : '0;
  assign acc         = col_valid_i & col_ready_o;
  assign all_empty   = &(col_empty_i | ~act);

  // lowest pending column goes first
  always_comb begin
    sel_idx = '0;
    sel_hit = 1'b0;
    for (int i = 0; i < MAX_COLS; i++) begin
      if (pend_q[i] && !sel_hit) begin
        sel_idx = IDX_W'(i);
        sel_hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (sel_hit)    kind_o = SYM_DATA;
    else if (eof_q) kind_o = SYM_EOF;
    else            kind_o = SYM_IDLE;
  end
  assign byte_o = data_q[sel_idx];

  // a tick load drains the old set while the new set is captured
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      eof_q   <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      if (tick_i)                 pend_q          <= acc;
      else if (load_i && sel_hit) pend_q[sel_idx] <= 1'b0;
      if (load_i && !sel_hit && eof_q) eof_q <= 1'b0;
      if (tick_i) begin
        if (|acc) begin
          frame_q <= 1'b1;
        end else if (all_empty && frame_q) begin
          eof_q   <= 1'b1;
          frame_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/colser_enc.sv
`timescale 1ns/1ps
module colser_enc
  import colser_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  sym_kind_e  kind_i,
  input  logic [7:0] byte_i,
  output logic [9:0] sym_o
);
  logic       rd_q, rd_mid, rd_nxt, unb6, unb4, alt7;
  logic [4:0] x;
  logic [2:0] y;
  logic [5:0] c6, s6;
  logic [3:0] c4, s4;

  assign x = byte_i[4:0];
  assign y = byte_i[7:5];

  always_comb begin
    c6     = code6(x);
    unb6   = ($countones(c6) != 3);
    rd_mid = rd_q ^ unb6;
    alt7   = (y == 3'd7) &&
             ((!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
              ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    c4     = alt7 ? 4'b0111 : code4(y);
    unb4   = ($countones(c4) != 2);
    if (kind_i == SYM_DATA) begin
      s6     = (rd_q && (unb6 || x == 5'd7)) ? ~c6 : c6;
      s4     = (rd_mid && (unb4 || y == 3'd3)) ? ~c4 : c4;
      rd_nxt = rd_mid ^ unb4;
    end else begin
      // K28.5 flips disparity, K28.7 keeps it
      s6     = rd_q ? 6'b110000 : 6'b001111;
      s4     = (kind_i == SYM_EOF) ? (rd_q ? 4'b0111 : 4'b1000)
                                   : (rd_q ? 4'b0101 : 4'b1010);
      rd_nxt = rd_q ^ (kind_i == SYM_IDLE);
    end
  end

  assign sym_o = lsb_first(s6, s4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_q <= 1'b0;
    else if (load_i) rd_q <= rd_nxt;
  end
endmodule

// File: rtl/colser_ddr.sv
`timescale 1ns/1ps
module colser_ddr (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [9:0] sym_i,
  output logic [1:0] ser_o
);
  logic [9:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= sym_i;
    else             sh_q <= {2'b00, sh_q[9:2]};
  end

  assign ser_o = sh_q[1:0];
endmodule

// File: rtl/colpar_serializer.sv
`timescale 1ns/1ps
module colpar_serializer
  import colser_pkg::*;
#(
  parameter int MAX_COLS = 4,
  parameter int NCOL_W   = $clog2(MAX_COLS + 1)
) (
  input  logic [0:0]            clk_i,
  input  logic                  rst_ni,
  input  logic [NCOL_W-1:0]     ncols_i,
  input  logic [MAX_COLS-1:0]   col_valid_i,
  input  logic [8*MAX_COLS-1:0] col_data_i,
  input  logic [MAX_COLS-1:0]   col_empty_i,
  output logic [MAX_COLS-1:0]   col_ready_o,
  output logic                  mclk_en_o,
  output logic [1:0]            ser_o
);
  logic                     slot_load, tick;
  logic [NCOL_W-1:0]        n_eff;
  logic [MAX_COLS-1:0][7:0] col_bytes;
  sym_kind_e                kind;
  logic [7:0]               sel_byte;
  logic [9:0]               sym;

  for (genvar i = 0; i < MAX_COLS; i++) begin : g_unpack
    assign col_bytes[i] = col_data_i[8*i +: 8];
  end

  colser_rate #(.MAX_COLS(MAX_COLS), .NCOL_W(NCOL_W)) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .ncols_i(ncols_i),
    .n_eff_o(n_eff), .load_o(slot_load), .tick_o(tick)
  );

  colser_gather #(.MAX_COLS(MAX_COLS), .NCOL_W(NCOL_W)) u_gather (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .load_i(slot_load),
    .n_eff_i(n_eff), .col_valid_i(col_valid_i), .col_data_i(col_bytes),
    .col_empty_i(col_empty_i), .col_ready_o(col_ready_o),
    .kind_o(kind), .byte_o(sel_byte)
  );

  colser_enc u_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(slot_load),
    .kind_i(kind), .byte_i(sel_byte), .sym_o(sym)
  );

  colser_ddr u_ddr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(slot_load),
    .sym_i(sym), .ser_o(ser_o)
  );

  assign mclk_en_o = tick;
endmodule

// File: rtl/colpar_serializer_chk.sv
`timescale 1ns/1ps
module colpar_serializer_chk #(
  parameter int MAX_COLS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [MAX_COLS-1:0] ready_i,
  input logic                tick_i,
  input logic                load_i,
  input logic [1:0]          ser_i
);
  logic [15:0] gap_q;
  logic        seen_q, started_q;
  int          dsum_q, pair;

  assign pair = 2 * (int'(ser_i[0]) + int'(ser_i[1])) - 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      seen_q    <= 1'b0;
      started_q <= 1'b0;
      dsum_q    <= 0;
    end else begin
      gap_q <= tick_i ? 16'd0 : ((gap_q == 16'hffff) ? gap_q : gap_q + 16'd1);
      if (tick_i) seen_q <= 1'b1;
      if (load_i) started_q <= 1'b1;
      if (started_q) dsum_q <= dsum_q + pair;
    end
  end

  AST_READY_IN_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i != '0) |-> tick_i); // R3

  AST_READY_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ready_i & (ready_i + 1'b1)) == '0)); // R3

  AST_TICK_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && seen_q) |-> (((int'(gap_q) + 1) % 5 == 0) && (int'(gap_q) + 1 <= 5 * MAX_COLS))); // R2

  AST_TICK_ON_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> load_i); // R9

  AST_RD_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && started_q) |-> ((dsum_q + pair == 0) || (dsum_q + pair == 2))); // R5
endmodule

bind colpar_serializer colpar_serializer_chk #(.MAX_COLS(MAX_COLS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(col_ready_o),
  .tick_i(mclk_en_o), .load_i(slot_load), .ser_i(ser_o)
);

// File: tb/colpar_serializer_test.sv
`timescale 1ns/1ps
module colpar_serializer_test;
  localparam int MAXC = 4;
  localparam int NW   = 3;
  localparam int MAXT = 128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NW-1:0]   ncols = '0;
  logic [MAXC-1:0] vld = '0, emp = '0, rdy;
  logic [8*MAXC-1:0] dat = '0;
  logic            men;
  logic [1:0]      ser;

  int errs = 0, checks = 0;
  logic [7:0] mbytes [MAXT][MAXC];
  int         mcnt [MAXT];
  bit         meof [MAXT];

  always #2 clk = ~clk;

  colpar_serializer #(.MAX_COLS(MAXC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ncols_i(ncols), .col_valid_i(vld),
    .col_data_i(dat), .col_empty_i(emp), .col_ready_o(rdy),
    .mclk_en_o(men), .ser_o(ser)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] t6(input int x);
    logic [5:0] tab [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
      6'b110101, 6'b101001, 6'b011001, 6'b111000, 6'b111001, 6'b100101,
      6'b010101, 6'b110100, 6'b001101, 6'b101100, 6'b011100, 6'b010111,
      6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010,
      6'b011010, 6'b111010, 6'b110011, 6'b100110, 6'b010110, 6'b110110,
      6'b001110, 6'b101110, 6'b011110, 6'b101011};
    return tab[x];
  endfunction

  function automatic logic [3:0] t4(input int y);
    logic [3:0] tab [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                            4'b1101, 4'b1010, 4'b0110, 4'b1110};
    return tab[y];
  endfunction

  // expected symbol in transmit order, first bit in the MSB
  function automatic logic [9:0] exp_sym(input int kind, input logic [7:0] b, input bit rd);
    logic [5:0] c6, s6;
    logic [3:0] c4, s4;
    int x, y, o;
    bit rm, alt;
    if (kind == 0) return rd ? 10'b1100000101 : 10'b0011111010;
    if (kind == 2) return rd ? 10'b1100000111 : 10'b0011111000;
    x  = int'(b[4:0]);
    y  = int'(b[7:5]);
    c6 = t6(x);
    o  = $countones(c6);
    if (x == 7)      s6 = rd ? ~c6 : c6;
    else if (o == 3) s6 = c6;
    else             s6 = rd ? ((o > 3) ? ~c6 : c6) : ((o > 3) ? c6 : ~c6);
    o  = $countones(s6);
    rm = (o > 3) ? 1'b1 : (o < 3) ? 1'b0 : rd;
    if (y == 7) begin
      alt = rm ? (x == 11 || x == 13 || x == 14) : (x == 17 || x == 18 || x == 20);
      c4  = alt ? 4'b0111 : 4'b1110;
    end else c4 = t4(y);
    o = $countones(c4);
    if (y == 3)      s4 = rm ? ~c4 : c4;
    else if (o == 2) s4 = c4;
    else             s4 = rm ? ((o > 2) ? ~c4 : c4) : ((o > 2) ? c4 : ~c4);
    return {s6, s4};
  endfunction

  task automatic run(input int cfg, input int nt);
    int nexp, kind, j, tk, m, k, r, o, cnt;
    bit active, rd, all_e;
    logic [9:0] rx, ev;
    logic [MAXC-1:0] mask;
    logic [7:0] b;
    string req;
    nexp   = (cfg == 0) ? 1 : (cfg > MAXC) ? MAXC : cfg;
    mask   = '0;
    for (int c = 0; c < nexp; c++) mask[c] = 1'b1;
    active = 1'b0;
    rd     = 1'b0;
    rx     = '0;
    k      = 0;
    @(negedge clk);
    rst_n = 1'b0;
    ncols = NW'(cfg);
    vld = '0; emp = '0; dat = '0;
    repeat (3) @(negedge clk);
    chk(ser == 2'b00, "R1", "ser in reset", ser, 0);
    rst_n = 1'b1;
    for (int n = 0; n <= 5 * nt * nexp + 5; n++) begin
      if (n > 0) @(negedge clk);
      if (n >= 1) begin
        // R6: ser[0] is the earlier bit of each pair
        rx = {rx[7:0], ser[0], ser[1]};
        if ((n - 1) % 5 == 4) begin
          j = (n - 1) / 5;
          kind = 0; b = '0; req = "R7";
          if (j == 0) req = "R1";
          else begin
            tk = (j - 1) / nexp;
            m  = (j - 1) % nexp + 1;
            if (m <= mcnt[tk]) begin
              kind = 1; b = mbytes[tk][m-1];
              req = (m == nexp) ? "R9" : "R4";
            end else if (m == 1 && meof[tk]) begin
              kind = 2; req = "R8";
            end
          end
          ev = exp_sym(kind, b, rd);
          chk(rx == ev, (kind == 1) ? {req, "/R5"} : req, $sformatf("symbol %0d N=%0d", j, nexp), rx, ev);
          o = $countones(ev);
          if (o > 5) rd = 1'b1;
          else if (o < 5) rd = 1'b0;
        end
      end
      if (n % (5 * nexp) == 0) begin
        chk(men == 1'b1, "R2", "matrix pulse", men, 1);
        if (k < nt) begin
          if (k == 0) begin vld = '0; emp = '1; end            // no frame yet: no marker
          else if (k == 1) begin vld = '1; emp = '0; dat = $urandom; end  // full period
          else if (k == 2 || k == 3) begin vld = '0; emp = '1; end        // marker once
          else begin
            r = $urandom % 6;
            if (r < 2) begin vld = '0; emp = '1; end
            else if (r == 2) begin vld = '1; emp = MAXC'($urandom); dat = $urandom; end
            else begin vld = MAXC'($urandom); emp = MAXC'($urandom); dat = $urandom; end
          end
          cnt = 0;
          for (int c = 0; c < nexp; c++)
            if (vld[c]) begin mbytes[k][cnt] = dat[8*c +: 8]; cnt++; end
          mcnt[k] = cnt;
          all_e   = &(emp | ~mask);
          meof[k] = 1'b0;
          if (cnt > 0) active = 1'b1;
          else if (all_e && active) begin meof[k] = 1'b1; active = 1'b0; end
        end else begin
          vld = '0; emp = '0;
        end
        chk(rdy == mask, "R3", "ready on pulse", rdy, mask);
        k++;
      end else begin
        chk(men == 1'b0 && rdy == '0, "R2/R3", "quiet between pulses", {men, rdy}, 0);
        // garbage between pulses must be ignored (R3)
        vld = MAXC'($urandom); emp = MAXC'($urandom); dat = $urandom;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    run(1, 60);
    run(4, 50);
    run(3, 50);
    run(0, 20);  // R2 clamp to 1
    run(7, 30);  // R2 clamp to MAX
    run(2, 50);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule